// File: doc/BRIEF.md
# CAN controller interrupt flag unit

This block sits beside a CAN protocol engine and turns its status conditions into latched flags and four separate CPU interrupt request lines. It watches three transmit buffer empty indications, a strobe for each correctly received frame, a receive-in-progress indicator, a sleep indicator paired with bus activity, and the receive and transmit error counters.

It tracks how full a two-slot receive queue is (a foreground slot the CPU reads and a background slot behind it) and raises an overrun when both slots are full while another frame is arriving. A set flag raises a request on its line when its enable bit is set. The transmit line, the receive line, the wakeup line and the error line are kept apart, so software can give each its own handler.

Software uses one narrow write port. A write with select 0 loads every enable bit. A write with select 1 clears each flag whose bit is 1 in the data.

Top module: `can_irq_flags`

## Requirements
- R1: While reset is asserted, flags_o, txe_o and all four interrupt lines are 0, whatever the inputs. After release, txe_o copies tx_empty_i one clock later.
- R2: txe_o[i] follows tx_empty_i[i] with one cycle of latency. irq_tx_o is high when any txe_o[i] has its enable bit set (write data bit 7+i, select 0). A buffer whose enable is 0 raises no request.
- R3: A pulse on rx_done_i while the foreground slot is empty sets the receive-full flag (flags_o bit 0) at the next edge. irq_rx_o follows when enable bit 0 is set.
- R4: A frame that arrives while the foreground slot is full is held in the background slot. When the CPU clears bit 0, the flag reads 0 for one cycle and then sets again as the held frame moves forward. A frame that arrives while both slots are full is dropped.
- R5: The overrun flag (bit 2) sets when both slots are full and rx_busy_i is high. It does not set while only one slot is full.
- R6: The wakeup flag (bit 1) sets when sleep_i and bus_act_i are both high. Bus activity outside sleep does not set it. irq_wake_o follows when enable bit 1 is set.
- R7: The receive warning flag (bit 3) and the transmit warning flag (bit 4) set once, when rec_i or tec_i respectively moves from below 96 to 96 or more. Neither sets again until its counter has gone back below 96.
- R8: The receive error-passive flag (bit 5) and the transmit error-passive flag (bit 6) set once, when rec_i or tec_i respectively moves from 127 or less to 128 or more. A value of 127 does not set them.
- R9: A select-1 write clears exactly the flags whose data bits are 1 and leaves every other flag as it was. A set event in the same cycle as its clear wins.
- R10: irq_err_o is the OR of flag bits 2 to 6, each gated by the enable bit at the same position. A set flag whose enable is 0 does not raise the line.
- R11: All interrupt lines are registered. A request appears one clock after the flag and the enable that cause it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_empty_i | input | NTX | Transmit buffer empty status, one bit per buffer |
| rx_done_i | input | 1 | One-cycle strobe for each correctly received frame |
| rx_busy_i | input | 1 | A frame is currently being received |
| sleep_i | input | 1 | Controller is in its internal sleep state |
| bus_act_i | input | 1 | Activity detected on the bus |
| rec_i | input | CW | Receive error counter |
| tec_i | input | CW | Transmit error counter |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = load enables, 1 = write-one-to-clear flags |
| reg_wdata_i | input | 7+NTX | Write data: bits 0..6 flag positions, bits 7.. transmit enables |
| flags_o | output | 7 | Latched flags: 0 rx-full, 1 wakeup, 2 overrun, 3/4 rx/tx warning, 5/6 rx/tx error-passive |
| txe_o | output | NTX | Registered transmit empty flags |
| irq_tx_o | output | 1 | Transmit interrupt request |
| irq_rx_o | output | 1 | Receive interrupt request |
| irq_wake_o | output | 1 | Wakeup interrupt request |
| irq_err_o | output | 1 | Error interrupt request |

## Verification
The counter thresholds are driven with values just under and at each limit, with a value that stays above the limit after a clear, and with a fall and a second rise. These separate an edge-triggered detector from a level-triggered one and find off-by-one limits. The receive queue gets one, two and three frames before the CPU clears, which separates a real background slot from a single flag and shows whether the third frame is dropped. Enable patterns that select one transmit buffer or one error source tell an OR of gated flags apart from an OR of raw flags. A clear written in the same cycle as a threshold crossing shows which one has priority.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
    localparam int FLAG_N   = 7;
    localparam int F_RXF    = 0;
    localparam int F_WAKE   = 1;
    localparam int F_OVR    = 2;
    localparam int F_THR0   = 3;   // four threshold flags occupy 3..6
    localparam int N_THR    = 4;

    typedef enum logic {
        SEL_ENABLE = 1'b0,
        SEL_CLEAR  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/can_thr_edge.sv
module can_thr_edge #(
    parameter int W     = 8,
    parameter int LIMIT = 96
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    output logic         hit_o
);
    localparam logic [W-1:0] LIM_V = LIMIT[W-1:0];

    logic arm_d, arm_q;

    always_comb begin
        arm_d = (cnt_i < LIM_V);
        hit_o = arm_q && (cnt_i >= LIM_V);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= 1'b1;
        else        arm_q <= arm_d;
    end
endmodule

// File: rtl/can_rxbuf_track.sv
module can_rxbuf_track (
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic busy_i,
    input  logic release_i,
    output logic full_o,
    output logic ovr_set_o
);
    typedef struct packed {
        logic fg;
        logic bg;
    } occ_t;

    occ_t occ_d, occ_q;
    logic move;

    always_comb begin
        move     = !occ_q.fg && occ_q.bg;
        occ_d.fg = (occ_q.fg && !release_i) || move;
        occ_d.bg = occ_q.bg && !move;
        if (done_i) begin
            if (!occ_d.fg)      occ_d.fg = 1'b1;
            else if (!occ_d.bg) occ_d.bg = 1'b1;
        end
        full_o    = occ_q.fg;
        ovr_set_o = occ_q.fg && occ_q.bg && busy_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end
endmodule

// File: rtl/can_irq_flags.sv
module can_irq_flags
    import can_irq_pkg::*;
#(
    parameter int NTX      = 3,
    parameter int CW       = 8,
    parameter int WARN_LIM = 96,
    parameter int PASS_LIM = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NTX-1:0]        tx_empty_i,
    input  logic                  rx_done_i,
    input  logic                  rx_busy_i,
    input  logic                  sleep_i,
    input  logic                  bus_act_i,
    input  logic [CW-1:0]         rec_i,
    input  logic [CW-1:0]         tec_i,
    input  logic                  reg_wr_i,
    input  logic                  reg_sel_i,
    input  logic [FLAG_N+NTX-1:0] reg_wdata_i,
    output logic [FLAG_N-1:0]     flags_o,
    output logic [NTX-1:0]        txe_o,
    output logic                  irq_tx_o,
    output logic                  irq_rx_o,
    output logic                  irq_wake_o,
    output logic                  irq_err_o
);
    localparam int TXIE_LSB = FLAG_N;

    typedef struct packed {
        logic [NTX-1:0]    txe;
        logic [NTX-1:0]    txie;
        logic [FLAG_N-1:0] en;
        logic [FLAG_N-1:1] lat;
        logic              irq_tx;
        logic              irq_rx;
        logic              irq_wake;
        logic              irq_err;
    } state_t;

    state_t st_d, st_q;

    logic              wr_en, wr_clr;
    logic [FLAG_N-1:0] clr;
    logic [FLAG_N-1:1] set;
    logic [N_THR-1:0]  thr_hit;
    logic              rx_full, ovr_set;

    assign wr_en  = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_ENABLE);
    assign wr_clr = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_CLEAR);
    assign clr    = wr_clr ? reg_wdata_i[FLAG_N-1:0] : '0;

    // even index watches the receive counter, odd the transmit counter;
    // the lower pair uses the warning limit, the upper pair the passive limit
    for (genvar i = 0; i < N_THR; i++) begin : g_thr
        localparam int LIM = (i < 2) ? WARN_LIM : PASS_LIM;
        can_thr_edge #(.W(CW), .LIMIT(LIM)) u_thr (
            .clk   (clk),
            .rst_n (rst_n),
            .cnt_i ((i % 2 == 0) ? rec_i : tec_i),
            .hit_o (thr_hit[i])
        );
    end

    can_rxbuf_track u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (rx_done_i),
        .busy_i    (rx_busy_i),
        .release_i (clr[F_RXF]),
        .full_o    (rx_full),
        .ovr_set_o (ovr_set)
    );

    always_comb begin
        st_d = st_q;

        st_d.txe = tx_empty_i;

        if (wr_en) begin
            st_d.en   = reg_wdata_i[FLAG_N-1:0];
            st_d.txie = reg_wdata_i[TXIE_LSB +: NTX];
        end

        set                            = '0;
        set[F_WAKE]                    = sleep_i && bus_act_i;
        set[F_OVR]                     = ovr_set;
        set[F_THR0 +: N_THR]           = thr_hit;
        st_d.lat = set | (st_q.lat & ~clr[FLAG_N-1:1]);

        st_d.irq_tx   = |(st_q.txe & st_q.txie);
        st_d.irq_rx   = rx_full && st_q.en[F_RXF];
        st_d.irq_wake = st_q.lat[F_WAKE] && st_q.en[F_WAKE];
        st_d.irq_err  = |(st_q.lat[FLAG_N-1:F_OVR] & st_q.en[FLAG_N-1:F_OVR]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o    = {st_q.lat, rx_full};
    assign txe_o      = st_q.txe;
    assign irq_tx_o   = st_q.irq_tx;
    assign irq_rx_o   = st_q.irq_rx;
    assign irq_wake_o = st_q.irq_wake;
    assign irq_err_o  = st_q.irq_err;
endmodule

// File: rtl/can_irq_flags_chk.sv
module can_irq_flags_chk #(
    parameter int NTX = 3,
    parameter int CW  = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NTX-1:0] tx_empty_i,
    input logic           rx_done_i,
    input logic           rx_busy_i,
    input logic           sleep_i,
    input logic           bus_act_i,
    input logic [CW-1:0]  rec_i,
    input logic [CW-1:0]  tec_i,
    input logic [6:0]     flags_o,
    input logic [NTX-1:0] txe_o,
    input logic           irq_rx_o,
    input logic           irq_err_o
);
    // R2
    txe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> txe_o == $past(tx_empty_i));

    // R3
    rxf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_i |=> flags_o[0]);

    // R11
    rx_irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flags_o[0] |=> !irq_rx_o);

    // R5
    ovr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_busy_i && !flags_o[0] && !flags_o[2]) |=> !flags_o[2]);

    // R6
    wake_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && bus_act_i) |=> flags_o[1]);

    // R7
    warn_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_i < 8'd96 && !flags_o[3]) |=> !flags_o[3]);

    // R8
    pass_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tec_i <= 8'd127 && !flags_o[6]) |=> !flags_o[6]);

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[6:2] == 5'd0) |=> !irq_err_o);
endmodule

bind can_irq_flags can_irq_flags_chk #(.NTX(NTX), .CW(CW)) u_chk (.*);

// File: tb/can_irq_flags_bench.sv
`timescale 1ns/1ps
module can_irq_flags_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] tx_empty_i = '0;
    logic       rx_done_i = 1'b0;
    logic       rx_busy_i = 1'b0;
    logic       sleep_i = 1'b0;
    logic       bus_act_i = 1'b0;
    logic [7:0] rec_i = '0;
    logic [7:0] tec_i = '0;
    logic       reg_wr_i = 1'b0;
    logic       reg_sel_i = 1'b0;
    logic [9:0] reg_wdata_i = '0;
    logic [6:0] flags_o;
    logic [2:0] txe_o;
    logic       irq_tx_o, irq_rx_o, irq_wake_o, irq_err_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    can_irq_flags u_can_irq_flags (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [9:0] data);
        reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = data;
        tick();
        reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic rx_pulse();
        rx_done_i = 1'b1; tick(); rx_done_i = 1'b0;
    endtask

    task automatic t_reset();
        tx_empty_i = 3'b111; sleep_i = 1'b1; bus_act_i = 1'b1; rec_i = 8'd200;
        repeat (3) tick();
        chk("R1 flags in reset", flags_o, 7'h00);
        chk("R1 txe in reset", txe_o, 3'b000);
        chk("R1 irqs in reset", {irq_tx_o, irq_rx_o, irq_wake_o, irq_err_o}, 4'h0);
        sleep_i = 1'b0; bus_act_i = 1'b0; rec_i = 8'd0;
        rst_n = 1'b1;
        tick();
        chk("R1 txe follows after release", txe_o, 3'b111);
        tx_empty_i = 3'b000;
        tick();
    endtask

    task automatic t_tx();
        wr(1'b0, 10'h100);               // enable buffer 1 only (bit 8)
        tx_empty_i = 3'b010;
        tick();
        chk("R2 txe copy", txe_o, 3'b010);
        chk("R11 tx irq one clock later", irq_tx_o, 1'b0);
        tick();
        chk("R2 tx irq enabled buffer", irq_tx_o, 1'b1);
        tx_empty_i = 3'b001;
        repeat (2) tick();
        chk("R2 tx irq disabled buffer", irq_tx_o, 1'b0);
        tx_empty_i = 3'b000;
        tick();
    endtask

    task automatic t_rx();
        wr(1'b0, 10'h001);
        rx_pulse();
        chk("R3 rx full set", flags_o[0], 1'b1);
        chk("R11 rx irq lag", irq_rx_o, 1'b0);
        tick();
        chk("R3 rx irq", irq_rx_o, 1'b1);
        rx_busy_i = 1'b1; tick(); rx_busy_i = 1'b0;
        chk("R5 no overrun with one slot", flags_o[2], 1'b0);
        rx_pulse();
        rx_busy_i = 1'b1; tick(); rx_busy_i = 1'b0;
        chk("R5 overrun with two slots", flags_o[2], 1'b1);
        rx_pulse();                      // third frame, dropped
        wr(1'b1, 10'h001);
        chk("R4 flag low after release", flags_o[0], 1'b0);
        tick();
        chk("R4 background moves forward", flags_o[0], 1'b1);
        chk("R9 overrun untouched", flags_o[2], 1'b1);
        wr(1'b1, 10'h001);
        tick();
        chk("R4 third frame dropped", flags_o[0], 1'b0);
        wr(1'b1, 10'h004);
        chk("R9 overrun cleared", flags_o[2], 1'b0);
    endtask

    task automatic t_wake();
        bus_act_i = 1'b1; tick();
        chk("R6 no wake when awake", flags_o[1], 1'b0);
        sleep_i = 1'b1; tick();
        chk("R6 wake set in sleep", flags_o[1], 1'b1);
        sleep_i = 1'b0; bus_act_i = 1'b0;
        wr(1'b0, 10'h002);
        tick();
        chk("R6 wake irq", irq_wake_o, 1'b1);
        wr(1'b1, 10'h002);
        chk("R9 wake cleared", flags_o[1], 1'b0);
    endtask

    task automatic t_thr();
        rec_i = 8'd95; tick();
        chk("R7 rec 95 no warning", flags_o[3], 1'b0);
        rec_i = 8'd96; tick();
        chk("R7 rec 96 warning", flags_o[3], 1'b1);
        rec_i = 8'd100;
        wr(1'b1, 10'h008);
        tick();
        chk("R7 no refire above limit", flags_o[3], 1'b0);
        rec_i = 8'd50; tick();
        rec_i = 8'd96; tick();
        chk("R7 rearm after fall", flags_o[3], 1'b1);
        tec_i = 8'd96; tick();
        chk("R7 tec warning", flags_o[4], 1'b1);
        tec_i = 8'd127; tick();
        chk("R8 tec 127 not passive", flags_o[6], 1'b0);
        tec_i = 8'd128; tick();
        chk("R8 tec 128 passive", flags_o[6], 1'b1);
        rec_i = 8'd200; tick();
        chk("R8 rec passive", flags_o[5], 1'b1);
        rec_i = 8'd50; tick();
        rec_i = 8'd96;
        reg_wr_i = 1'b1; reg_sel_i = 1'b1; reg_wdata_i = 10'h008;
        tick();
        reg_wr_i = 1'b0; reg_wdata_i = '0;
        chk("R9 set wins over clear", flags_o[3], 1'b1);
    endtask

    task automatic t_err();
        wr(1'b0, 10'h040);
        tick();
        chk("R10 err irq from enabled flag", irq_err_o, 1'b1);
        wr(1'b1, 10'h040);
        tick();
        chk("R10 disabled flags ignored", irq_err_o, 1'b0);
        chk("R9 other flags kept", flags_o[5], 1'b1);
        wr(1'b0, 10'h008);
        tick();
        chk("R10 err irq from warning", irq_err_o, 1'b1);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_tx();
        t_rx();
        t_wake();
        t_thr();
        t_err();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule